// File: doc/BRIEF.md
# Speculative Load Queue Snoop Checker

This block tracks loads that a core has issued out of order so that the machine can still present a sequentially consistent view of memory. The front end claims a slot for each load in program order at the tail of a circular queue. When the load executes, its address is written into that slot. From then on, every invalidating bus operation seen by the core's snoop port is compared against the cache-line address of every executed entry. An entry that matches is marked as needing replay.

Loads leave the queue from the head as the core commits them. If the committing load carries a replay mark, the block raises a flush request and reports that load's slot index, so the pipeline can restart from it. In the next cycle the whole queue is emptied. Conflicts are expected to be rare, so paying for a full flush on each one is an accepted cost. Returning load data, the cache and the pipeline itself are handled elsewhere.

Top module: `lq_snoop_checker`

## Requirements
- R1: After reset, `lq_empty` is 1, `lq_full` is 0, `alloc_idx` is 0 and `flush_req` is 0.
- R2: An allocation is accepted when `alloc_req` is 1 and `lq_full` is 0, and it lands in slot `alloc_idx`. Afterwards `alloc_idx` advances by one, modulo DEPTH. After DEPTH allocations with no commit, `lq_full` is 1.
- R3: While `lq_full` is 1, an allocation request has no effect. The tail index and the occupancy do not change.
- R4: A commit (`commit_req` with the queue not empty) of an unmarked head retires it without a flush. Once every entry has retired, `lq_empty` is 1.
- R5: A snoop with `snoop_cmd` 2'b01 (bus write) or 2'b10 (bus upgrade) marks every executed entry whose line address (address shifted right by LINE_OFF, 6 by default) equals the snoop's line address.
- R6: Committing a marked head raises `flush_req` combinationally in that same cycle, with `flush_idx` equal to the head slot.
- R7: Offset bits below the line size are ignored in the comparison, and addresses on different lines never match.
- R8: A snoop with `snoop_cmd` 2'b00 (bus read) or 2'b11 (reserved) marks nothing.
- R9: A snoop never marks an entry that has been allocated but has not yet executed. This includes an entry whose address is written in the same cycle as the snoop.
- R10: In the cycle after `flush_req`, the queue is empty and `alloc_idx` is 0, with all marks cleared.
- R11: An allocation requested in the cycle of a flush is dropped.
- R12: A snoop marks younger entries as well as the head. A marked younger entry flushes when it later commits at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Claim a slot at the tail for the next load in program order |
| alloc_idx | output | IDX_W | Slot that the next accepted allocation uses |
| lq_full | output | 1 | All DEPTH slots are in use |
| lq_empty | output | 1 | No slot is in use |
| exec_valid | input | 1 | A load has executed and its address is valid |
| exec_idx | input | IDX_W | Slot of the executing load |
| exec_addr | input | ADDR_W | Byte address of the executing load |
| snoop_valid | input | 1 | A snooped bus operation is present |
| snoop_cmd | input | 2 | 00 read, 01 write, 10 upgrade, 11 reserved |
| snoop_addr | input | ADDR_W | Byte address of the snooped operation |
| commit_req | input | 1 | The oldest load is committing |
| flush_req | output | 1 | The committing load was marked; flush and restart from it |
| flush_idx | output | IDX_W | Slot of the load that caused the flush |

## Verification
The assertions assume that `exec_idx` names a slot the front end has already allocated. They also assume `commit_req` is only raised for a load that the core is really retiring, and never while the queue is empty. The bench allocates before it executes, uses only slots it has allocated, and commits only when it knows the occupancy to be nonzero. Snoops are driven one per cycle with a defined command and address. The bench keeps the expected tail index itself, so it can predict every slot.

// File: rtl/lq_pkg.sv
package lq_pkg;
    localparam int LQ_DEPTH    = 8;
    localparam int LQ_ADDR_W   = 32;
    localparam int LQ_LINE_OFF = 6;

    typedef enum logic [1:0] {
        SNP_READ    = 2'b00,
        SNP_WRITE   = 2'b01,
        SNP_UPGRADE = 2'b10,
        SNP_RSVD    = 2'b11
    } snoop_cmd_e;

    function automatic logic is_invalidating(input logic [1:0] cmd);
        return (cmd == SNP_WRITE) || (cmd == SNP_UPGRADE);
    endfunction
endpackage

// File: rtl/lq_ring.sv
module lq_ring #(
    parameter int DEPTH = lq_pkg::LQ_DEPTH,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ring_t;

    ring_t ring_d, ring_q;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ring_d = ring_q;
        if (clear) begin
            ring_d = '0;
        end else begin
            if (push) ring_d.tail = bump(ring_q.tail);
            if (pop)  ring_d.head = bump(ring_q.head);
            ring_d.count = ring_q.count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    assign head  = ring_q.head;
    assign tail  = ring_q.tail;
    assign full  = (ring_q.count == CNT_W'(DEPTH));
    assign empty = (ring_q.count == '0);
endmodule

// File: rtl/lq_line_cam.sv
module lq_line_cam #(
    parameter int DEPTH  = lq_pkg::LQ_DEPTH,
    parameter int LINE_W = lq_pkg::LQ_ADDR_W - lq_pkg::LQ_LINE_OFF
) (
    input  logic [DEPTH-1:0]             armed,
    input  logic [DEPTH-1:0][LINE_W-1:0] line,
    input  logic                         probe_en,
    input  logic [LINE_W-1:0]            probe_line,
    output logic [DEPTH-1:0]             hit
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = probe_en && armed[g] && (line[g] == probe_line);
    end
endmodule

// File: rtl/lq_snoop_checker.sv
module lq_snoop_checker #(
    parameter int DEPTH    = lq_pkg::LQ_DEPTH,
    parameter int ADDR_W   = lq_pkg::LQ_ADDR_W,
    parameter int LINE_OFF = lq_pkg::LQ_LINE_OFF,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int LINE_W  = ADDR_W - LINE_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              lq_full,
    output logic              lq_empty,
    input  logic              exec_valid,
    input  logic [IDX_W-1:0]  exec_idx,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              commit_req,
    output logic              flush_req,
    output logic [IDX_W-1:0]  flush_idx
);
    typedef struct packed {
        logic [DEPTH-1:0]             busy;
        logic [DEPTH-1:0]             filled;
        logic [DEPTH-1:0]             mark;
        logic [DEPTH-1:0][LINE_W-1:0] line;
    } lq_state_t;

    lq_state_t st_d, st_q;

    logic [IDX_W-1:0] head_idx, tail_idx;
    logic             full_w, empty_w;
    logic             commit_fire, retire_fire, flush_fire, alloc_fire;
    logic [DEPTH-1:0] snoop_hit;

    assign commit_fire = commit_req && !empty_w;
    assign flush_fire  = commit_fire && st_q.mark[head_idx];
    assign retire_fire = commit_fire && !st_q.mark[head_idx];
    assign alloc_fire  = alloc_req && !full_w && !flush_fire;

    lq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (alloc_fire),
        .pop   (retire_fire),
        .clear (flush_fire),
        .head  (head_idx),
        .tail  (tail_idx),
        .full  (full_w),
        .empty (empty_w)
    );

    lq_line_cam #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_cam (
        .armed      (st_q.busy & st_q.filled),
        .line       (st_q.line),
        .probe_en   (snoop_valid && lq_pkg::is_invalidating(snoop_cmd)),
        .probe_line (snoop_addr[ADDR_W-1:LINE_OFF]),
        .hit        (snoop_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mark = st_q.mark | snoop_hit;
        if (exec_valid && st_q.busy[exec_idx]) begin
            st_d.filled[exec_idx] = 1'b1;
            st_d.line[exec_idx]   = exec_addr[ADDR_W-1:LINE_OFF];
        end
        if (retire_fire) begin
            st_d.busy[head_idx]   = 1'b0;
            st_d.filled[head_idx] = 1'b0;
            st_d.mark[head_idx]   = 1'b0;
        end
        if (alloc_fire) begin
            st_d.busy[tail_idx]   = 1'b1;
            st_d.filled[tail_idx] = 1'b0;
            st_d.mark[tail_idx]   = 1'b0;
        end
        if (flush_fire) begin
            st_d.busy   = '0;
            st_d.filled = '0;
            st_d.mark   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alloc_idx = tail_idx;
    assign lq_full   = full_w;
    assign lq_empty  = empty_w;
    assign flush_req = flush_fire;
    assign flush_idx = head_idx;
endmodule

// File: rtl/lq_snoop_chk.sv
module lq_snoop_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_req,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             lq_full,
    input logic             lq_empty,
    input logic             commit_req,
    input logic             flush_req
);
    a_r2_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lq_full && lq_empty));

    a_r2_alloc_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !lq_full && !flush_req) |=> (alloc_idx != $past(alloc_idx)));

    a_r3_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && lq_full && !commit_req) |=> ($stable(alloc_idx) && lq_full));

    a_r6_flush_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (commit_req && !lq_empty));

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (lq_empty && (alloc_idx == '0)));

    a_r4_empty_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        lq_empty |-> !flush_req);
endmodule

bind lq_snoop_checker lq_snoop_chk #(.IDX_W($clog2(DEPTH))) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_req),
    .alloc_idx  (alloc_idx),
    .lq_full    (lq_full),
    .lq_empty   (lq_empty),
    .commit_req (commit_req),
    .flush_req  (flush_req)
);

// File: tb/sim_lq_snoop_checker.sv
module sim_lq_snoop_checker;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_req = 1'b0;
    logic [IDX_W-1:0]  alloc_idx;
    logic              lq_full, lq_empty;
    logic              exec_valid = 1'b0;
    logic [IDX_W-1:0]  exec_idx = '0;
    logic [ADDR_W-1:0] exec_addr = '0;
    logic              snoop_valid = 1'b0;
    logic [1:0]        snoop_cmd = 2'b00;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic              commit_req = 1'b0;
    logic              flush_req;
    logic [IDX_W-1:0]  flush_idx;

    int checks = 0;
    int errors = 0;
    int exp_tail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lq_snoop_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_OFF(6)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_idx(alloc_idx),
        .lq_full(lq_full), .lq_empty(lq_empty),
        .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
        .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
        .commit_req(commit_req), .flush_req(flush_req), .flush_idx(flush_idx)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        alloc_req = 0; exec_valid = 0; snoop_valid = 0; commit_req = 0;
        snoop_cmd = 2'b00;
    endtask

    task automatic alloc_one();
        alloc_req = 1; #1;
        check("R2", "alloc slot", int'(alloc_idx), exp_tail);
        step(); idle();
        exp_tail = (exp_tail + 1) % DEPTH;
    endtask

    task automatic exec_one(input int idx, input logic [ADDR_W-1:0] a);
        exec_valid = 1; exec_idx = IDX_W'(idx); exec_addr = a;
        step(); idle();
    endtask

    task automatic snoop_one(input logic [1:0] cmd, input logic [ADDR_W-1:0] a);
        snoop_valid = 1; snoop_cmd = cmd; snoop_addr = a;
        step(); idle();
    endtask

    task automatic commit_expect(input string req, input int exp_flush, input int exp_idx);
        commit_req = 1; #1;
        check(req, "flush_req at commit", int'(flush_req), exp_flush);
        if (exp_flush != 0) check(req, "flush_idx", int'(flush_idx), exp_idx);
        step(); idle();
    endtask

    task automatic t_reset();
        #1;
        check("R1", "empty", int'(lq_empty), 1);
        check("R1", "full", int'(lq_full), 0);
        check("R1", "alloc_idx", int'(alloc_idx), 0);
        check("R1", "flush_req", int'(flush_req), 0);
    endtask

    task automatic t_fill_drain();
        for (int i = 0; i < DEPTH; i++) alloc_one();
        check("R2", "full after DEPTH allocs", int'(lq_full), 1);
        alloc_req = 1; step(); idle();
        check("R3", "still full after stalled alloc", int'(lq_full), 1);
        commit_expect("R4", 0, 0);
        check("R3", "tail unchanged by stalled alloc", int'(alloc_idx), 0);
        check("R3", "not full after one retire", int'(lq_full), 0);
        for (int i = 1; i < DEPTH; i++) commit_expect("R4", 0, 0);
        check("R4", "empty after drain", int'(lq_empty), 1);
    endtask

    task automatic t_snoop_mark();
        int base = exp_tail;
        alloc_one(); alloc_one(); alloc_one();
        exec_one(base, 32'h0000_1000);
        exec_one(base + 1, 32'h0000_2040);
        exec_one(base + 2, 32'h0000_3000);
        snoop_one(2'b01, 32'h0000_207C);
        commit_expect("R5", 0, 0);
        commit_expect("R6", 1, base + 1);
        check("R10", "empty after flush", int'(lq_empty), 1);
        check("R10", "tail reset after flush", int'(alloc_idx), 0);
        exp_tail = 0;
    endtask

    task automatic t_read_ignored();
        alloc_one(); alloc_one();
        exec_one(0, 32'h0000_4000);
        exec_one(1, 32'h0000_5000);
        snoop_one(2'b00, 32'h0000_4000);
        snoop_one(2'b01, 32'h0000_4040);
        snoop_one(2'b11, 32'h0000_5000);
        commit_expect("R8", 0, 0);
        commit_expect("R7", 0, 0);
        check("R8", "empty after clean retire", int'(lq_empty), 1);
    endtask

    task automatic t_unfilled();
        int base = exp_tail;
        alloc_one(); alloc_one();
        exec_one(base, 32'h0000_6000);
        snoop_one(2'b10, 32'h0000_7000);
        snoop_valid = 1; snoop_cmd = 2'b10; snoop_addr = 32'h0000_7000;
        exec_valid = 1; exec_idx = IDX_W'(base + 1); exec_addr = 32'h0000_7000;
        step(); idle();
        commit_expect("R9", 0, 0);
        commit_expect("R9", 0, 0);
        check("R9", "empty", int'(lq_empty), 1);
    endtask

    task automatic t_flush_drops_alloc();
        int base = exp_tail;
        alloc_one(); alloc_one();
        exec_one(base, 32'h0000_8000);
        exec_one(base + 1, 32'h0000_9000);
        snoop_one(2'b10, 32'h0000_9010);
        commit_expect("R12", 0, 0);
        alloc_req = 1;
        commit_expect("R12", 1, base + 1);
        check("R11", "empty after flush with alloc", int'(lq_empty), 1);
        check("R11", "alloc dropped", int'(alloc_idx), 0);
        exp_tail = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fill_drain();
        t_snoop_mark();
        t_read_ignored();
        t_unfilled();
        t_flush_drops_alloc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule